// File: doc/BRIEF.md
# Inbound Address Decode Windows

This block translates inbound bus addresses for a bridge. Software programs six decode windows and two base address ranges through a simple register port. Each window has four fields: a base, a size mask in 64 KB units, a remap base, and a tag made of a 4-bit target ID and an 8-bit attribute. Each base address range has a power-of-two size and an enable. An address is only considered when at least one enabled base address range claims it. The enabled windows are then compared against it in parallel.

Lookups arrive on a valid/ready stream. A lookup is accepted on a rising edge where `lk_valid` and `lk_ready` are both high. Its result appears on the result stream one cycle later. The result carries a hit or miss flag, the winning window index, the target ID, the attribute and the translated address. When the consumer holds `res_ready` low, the result register keeps its contents. `lk_ready` then drops, so no new lookup is taken until the held result is consumed. Every lookup is either a hit or a miss; none is dropped. The register port is plain: writes take effect on the clock edge, and reads return combinationally.

Top module: `addr_decode_windows`

## Requirements
- R1: After reset, every window and base address range register reads zero. Every lookup returns a miss.
- R2: Window control readback has this layout: bits 31:16 are size-minus-one in 64 KB units, bits 15:8 the attribute, bits 7:4 the target ID, bit 0 the enable, and bits 3:1 read zero. Base and remap registers keep bits 31:16 and read zero in bits 15:0. A range control register reads bits 31:16 plus bit 0.
- R3: Window n (n = 0..4) has its control at 0x1820+16n, its base at +4 and its remap at +0xC. Window 5 uses 0x1880, 0x1884 and 0x188C. Range 1 has its control at 0x1804 and its base at 0x0018. Range 2 uses 0x1808 and 0x0020.
- R4: An enabled window matches when address bits 31:16 and the window base agree on every bit that is clear in the size field. The match covers the whole range up to its last byte.
- R5: On a hit, the result carries the window index, the target ID and the attribute of the winning window.
- R6: The translated address takes the remap bits where the size field is clear and the incoming address bits elsewhere. Bits 15:0 always pass through.
- R7: A window hit counts only when an enabled range claims the address, meaning the address lies in [base, base+size) for that range. Otherwise the result is a miss.
- R8: When several windows match, the lowest-numbered window wins.
- R9: A miss sets `res_miss`, clears `res_hit`, and returns zero in the index, target, attribute and address fields.
- R10: A window whose enable bit is clear never matches.
- R11: A lookup accepted at one edge produces `res_valid` one cycle later. While `res_valid` is high and `res_ready` is low, the result is held and `lk_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_addr | input | 32 | Inbound address to decode |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | A window claimed the address |
| res_miss | output | 1 | No window claimed the address |
| res_win | output | 3 | Winning window index |
| res_target | output | 4 | Target ID of the winning window |
| res_attr | output | 8 | Attribute of the winning window |
| res_addr | output | 32 | Translated address |

## Verification
The lookups are chosen to separate the cases that matter:
- Addresses inside, on the last byte of, and just past a window's range separate the size-mask compare from plain equality.
- An address covered by two windows exposes the priority order. Disabling the lower window then shows that its enable bit is honoured.
- Addresses outside every enabled range, and the same address after a range is enabled or disabled, show that the range gate acts independently of the windows.
- A burst under a stalling consumer checks result ordering and hold behaviour.
- Writes of all-ones patterns show which register bits are stored.

// File: rtl/adw_pkg.sv
package adw_pkg;
  localparam int NUM_WIN   = 6;
  localparam int NUM_BAR   = 2;
  localparam int ADDR_W    = 32;
  localparam int PAGE_W    = 16;
  localparam int HI_W      = ADDR_W - PAGE_W;
  localparam int WIN_IDX_W = $clog2(NUM_WIN);
  localparam int OFF_W     = 16;

  typedef struct packed {
    logic [HI_W-1:0] size_m1;
    logic [7:0]      attr;
    logic [3:0]      tgt;
    logic            en;
    logic [HI_W-1:0] base;
    logic [HI_W-1:0] remap;
  } win_cfg_t;

  typedef struct packed {
    logic [HI_W-1:0] size_m1;
    logic            en;
    logic [HI_W-1:0] base;
  } bar_cfg_t;

  // windows 0..4 are packed at a 16-byte stride, the last one sits apart
  function automatic logic [OFF_W-1:0] win_ctrl_off(input int idx);
    return (idx < 5) ? OFF_W'(32'h1820 + 16 * idx) : OFF_W'(32'h1880);
  endfunction

  function automatic logic [OFF_W-1:0] win_base_off(input int idx);
    return OFF_W'(win_ctrl_off(idx) + 16'h0004);
  endfunction

  function automatic logic [OFF_W-1:0] win_remap_off(input int idx);
    return OFF_W'(win_ctrl_off(idx) + 16'h000C);
  endfunction

  function automatic logic [OFF_W-1:0] bar_ctrl_off(input int idx);
    return OFF_W'(32'h1804 + 4 * idx);
  endfunction

  function automatic logic [OFF_W-1:0] bar_base_off(input int idx);
    return OFF_W'(32'h0018 + 8 * idx);
  endfunction
endpackage

// File: rtl/adw_regfile.sv
module adw_regfile
  import adw_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [OFF_W-1:0]             addr,
  input  logic [ADDR_W-1:0]            wdata,
  output logic [ADDR_W-1:0]            rdata,
  output win_cfg_t [NUM_WIN-1:0]       win_o,
  output bar_cfg_t [NUM_BAR-1:0]       bar_o
);
  logic [NUM_WIN-1:0] ctrl_rd_sel;
  logic [NUM_WIN-1:0] addr_rd_sel;
  logic               unused_wdata;

  assign unused_wdata = ^{wdata[3:1], wdata[PAGE_W-1:8]};

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam logic [OFF_W-1:0] CTRL_A  = win_ctrl_off(i);
    localparam logic [OFF_W-1:0] BASE_A  = win_base_off(i);
    localparam logic [OFF_W-1:0] REMAP_A = win_remap_off(i);
    win_cfg_t q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (we) begin
        if (addr == CTRL_A) begin
          q.size_m1 <= wdata[ADDR_W-1:PAGE_W];
          q.attr    <= wdata[15:8];
          q.tgt     <= wdata[7:4];
          q.en      <= wdata[0];
        end
        if (addr == BASE_A)  q.base  <= wdata[ADDR_W-1:PAGE_W];
        if (addr == REMAP_A) q.remap <= wdata[ADDR_W-1:PAGE_W];
      end
    end

    assign win_o[i]       = q;
    assign ctrl_rd_sel[i] = (addr == CTRL_A);
    assign addr_rd_sel[i] = (addr == BASE_A) || (addr == REMAP_A);
  end

  for (genvar b = 0; b < NUM_BAR; b++) begin : g_bar
    localparam logic [OFF_W-1:0] CTRL_A = bar_ctrl_off(b);
    localparam logic [OFF_W-1:0] BASE_A = bar_base_off(b);
    bar_cfg_t q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (we) begin
        if (addr == CTRL_A) begin
          q.size_m1 <= wdata[ADDR_W-1:PAGE_W];
          q.en      <= wdata[0];
        end
        if (addr == BASE_A) q.base <= wdata[ADDR_W-1:PAGE_W];
      end
    end

    assign bar_o[b] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (addr == win_ctrl_off(i))
        rdata = {win_o[i].size_m1, win_o[i].attr, win_o[i].tgt, 3'b000, win_o[i].en};
      if (addr == win_base_off(i))
        rdata = {win_o[i].base, {PAGE_W{1'b0}}};
      if (addr == win_remap_off(i))
        rdata = {win_o[i].remap, {PAGE_W{1'b0}}};
    end
    for (int b = 0; b < NUM_BAR; b++) begin
      if (addr == bar_ctrl_off(b))
        rdata = {bar_o[b].size_m1, {(PAGE_W-1){1'b0}}, bar_o[b].en};
      if (addr == bar_base_off(b))
        rdata = {bar_o[b].base, {PAGE_W{1'b0}}};
    end
  end

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctrl_rd_sel) |-> (rdata[3:1] == 3'b000)); // R2
  AST_ADDR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (|addr_rd_sel) |-> (rdata[PAGE_W-1:0] == '0)); // R2
endmodule

// File: rtl/adw_window_match.sv
module adw_window_match
  import adw_pkg::*;
(
  input  win_cfg_t            cfg,
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit,
  output logic [ADDR_W-1:0]   xlat_addr
);
  logic [HI_W-1:0] page;
  logic [HI_W-1:0] fixed_bits;

  assign page       = addr[ADDR_W-1:PAGE_W];
  assign fixed_bits = ~cfg.size_m1;
  assign hit        = cfg.en && ((page & fixed_bits) == (cfg.base & fixed_bits));
  assign xlat_addr  = {(cfg.remap & fixed_bits) | (page & cfg.size_m1),
                       addr[PAGE_W-1:0]};
endmodule

// File: rtl/adw_bar_claim.sv
module adw_bar_claim
  import adw_pkg::*;
(
  input  bar_cfg_t [NUM_BAR-1:0] bar,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   claim
);
  logic [NUM_BAR-1:0] in_range;

  for (genvar b = 0; b < NUM_BAR; b++) begin : g_rng
    assign in_range[b] = bar[b].en &&
      ((addr[ADDR_W-1:PAGE_W] & ~bar[b].size_m1) == (bar[b].base & ~bar[b].size_m1));
  end

  assign claim = |in_range;
endmodule

// File: rtl/addr_decode_windows.sv
module addr_decode_windows
  import adw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [15:0]           reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  lk_valid,
  output logic                  lk_ready,
  input  logic [31:0]           lk_addr,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic                  res_hit,
  output logic                  res_miss,
  output logic [2:0]            res_win,
  output logic [3:0]            res_target,
  output logic [7:0]            res_attr,
  output logic [31:0]           res_addr
);
  win_cfg_t [NUM_WIN-1:0] win_cfg;
  bar_cfg_t [NUM_BAR-1:0] bar_cfg;
  logic [NUM_WIN-1:0]     raw_hit;
  logic [NUM_WIN-1:0]     grant;
  logic [ADDR_W-1:0]      win_addr [NUM_WIN];
  logic                   claimed;
  logic                   in_fire;

  logic                   nx_hit;
  logic [WIN_IDX_W-1:0]   nx_win;
  logic [3:0]             nx_tgt;
  logic [7:0]             nx_attr;
  logic [ADDR_W-1:0]      nx_addr;

  adw_regfile u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .win_o (win_cfg),
    .bar_o (bar_cfg)
  );

  adw_bar_claim u_claim (
    .bar   (bar_cfg),
    .addr  (lk_addr),
    .claim (claimed)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
    adw_window_match u_match (
      .cfg       (win_cfg[i]),
      .addr      (lk_addr),
      .hit       (raw_hit[i]),
      .xlat_addr (win_addr[i])
    );
  end

  // lowest index wins; the range gate kills every grant at once
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      grant[i] = raw_hit[i] && claimed && !taken;
      taken    = taken || (raw_hit[i] && claimed);
    end
  end

  always_comb begin
    nx_hit  = 1'b0;
    nx_win  = '0;
    nx_tgt  = '0;
    nx_attr = '0;
    nx_addr = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (grant[i]) begin
        nx_hit  = 1'b1;
        nx_win  = WIN_IDX_W'(i);
        nx_tgt  = win_cfg[i].tgt;
        nx_attr = win_cfg[i].attr;
        nx_addr = win_addr[i];
      end
    end
  end

  assign lk_ready = !res_valid || res_ready;
  assign in_fire  = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_miss   <= 1'b0;
      res_win    <= '0;
      res_target <= '0;
      res_attr   <= '0;
      res_addr   <= '0;
    end else begin
      if (in_fire) begin
        res_valid  <= 1'b1;
        res_hit    <= nx_hit;
        res_miss   <= !nx_hit;
        res_win    <= nx_win;
        res_target <= nx_tgt;
        res_attr   <= nx_attr;
        res_addr   <= nx_addr;
      end else if (res_ready) begin
        res_valid  <= 1'b0;
      end
    end
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R8
  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit != res_miss)); // R9
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> res_valid); // R11
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) &&
                                   $stable(res_hit) && $stable(res_win))); // R11
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss) |-> (res_addr == '0 && res_target == '0)); // R9
endmodule

// File: tb/addr_decode_windows_test.sv
module addr_decode_windows_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit, res_miss;
  logic [2:0]  res_win;
  logic [3:0]  res_target;
  logic [7:0]  res_attr;
  logic [31:0] res_addr;

  int checks = 0;
  int failures = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  typedef struct {
    logic        hit;
    logic [2:0]  win;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [31:0] addr;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  addr_decode_windows uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_ready(res_ready), .res_hit(res_hit), .res_miss(res_miss),
    .res_win(res_win), .res_target(res_target), .res_attr(res_attr),
    .res_addr(res_addr)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    #3;
    res_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor: a result visible with ready high is consumed at the next edge
  logic        stalled = 1'b0;
  logic [31:0] held_addr;
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (stalled) begin
        checks++;
        if (res_addr !== held_addr) begin
          failures++;
          $display("FAIL R11 held result changed: actual=%h expected=%h", res_addr, held_addr);
        end
      end
      if (res_ready) begin
        stalled = 1'b0;
        checks++;
        if (sb.size() == 0) begin
          failures++;
          $display("FAIL R11 unexpected result: actual addr=%h expected=none", res_addr);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (res_hit !== e.hit || res_miss !== !e.hit || res_win !== e.win ||
              res_target !== e.tgt || res_attr !== e.attr || res_addr !== e.addr) begin
            failures++;
            $display("FAIL %s actual hit=%b miss=%b win=%0d tgt=%h attr=%h addr=%h expected hit=%b win=%0d tgt=%h attr=%h addr=%h",
                     e.req, res_hit, res_miss, res_win, res_target, res_attr, res_addr,
                     e.hit, e.win, e.tgt, e.attr, e.addr);
          end
        end
      end else begin
        stalled   = 1'b1;
        held_addr = res_addr;
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #3;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #3;
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] e, input string req);
    @(posedge clk); #3;
    reg_addr = a;
    @(negedge clk);
    checks++;
    if (reg_rdata !== e) begin
      failures++;
      $display("FAIL %s reg %h actual=%h expected=%h", req, a, reg_rdata, e);
    end
  endtask

  task automatic lookup(input logic [31:0] a, input logic hit, input logic [2:0] w,
                        input logic [3:0] t, input logic [7:0] at,
                        input logic [31:0] xa, input string req);
    exp_t e;
    bit rdy;
    e.hit = hit; e.win = w; e.tgt = t; e.attr = at; e.addr = xa; e.req = req;
    sb.push_back(e);
    @(posedge clk); #3;
    lk_valid = 1'b1; lk_addr = a;
    forever begin
      @(negedge clk);
      rdy = lk_ready;
      @(posedge clk);
      if (rdy) break;
    end
    #3 lk_valid = 1'b0;
    if (!bp_mode) begin
      @(negedge clk);
      checks++;
      if (res_valid !== 1'b1) begin
        failures++;
        $display("FAIL R11 latency: actual res_valid=%b expected=1", res_valid);
      end
    end
  endtask

  task automatic miss(input logic [31:0] a, input string req);
    lookup(a, 1'b0, 3'd0, 4'h0, 8'h00, 32'h0, req);
  endtask

  task automatic drain;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R1: reset state
    rd_chk(16'h1820, 32'h0, "R1");
    rd_chk(16'h1884, 32'h0, "R1");
    rd_chk(16'h188C, 32'h0, "R1");
    rd_chk(16'h1804, 32'h0, "R1");
    rd_chk(16'h0018, 32'h0, "R1");
    miss(32'h0000_1000, "R1");
    drain();

    // R2: stored bits
    wr(16'h1830, 32'hFFFF_FFFF); rd_chk(16'h1830, 32'hFFFF_FFF1, "R2");
    wr(16'h1834, 32'h1234_ABCD); rd_chk(16'h1834, 32'h1234_0000, "R2");
    wr(16'h183C, 32'hFFFF_5555); rd_chk(16'h183C, 32'hFFFF_0000, "R2");
    wr(16'h1808, 32'hFFFF_FFFF); rd_chk(16'h1808, 32'hFFFF_0001, "R2");
    wr(16'h1830, 0); wr(16'h1834, 0); wr(16'h183C, 0); wr(16'h1808, 0);

    // program ranges and windows (R3 offsets)
    wr(16'h0018, 32'h0000_0000); wr(16'h1804, 32'h0FFF_0001);
    wr(16'h1820, 32'h03FF_E001); wr(16'h1824, 32'h0); wr(16'h182C, 32'h0);
    wr(16'h1830, 32'h03FF_D011); wr(16'h1834, 32'h0400_0000); wr(16'h183C, 32'h0800_0000);
    wr(16'h1880, 32'h0000_BB51); wr(16'h1884, 32'h0800_0000); wr(16'h188C, 32'h2222_0000);
    rd_chk(16'h1880, 32'h0000_BB51, "R3");

    lookup(32'h0012_3456, 1, 3'd0, 4'h0, 8'hE0, 32'h0012_3456, "R5");
    lookup(32'h0412_3456, 1, 3'd1, 4'h1, 8'hD0, 32'h0812_3456, "R6");
    lookup(32'h0800_1234, 1, 3'd5, 4'h5, 8'hBB, 32'h2222_1234, "R3");
    miss(32'h0801_0000, "R4");
    lookup(32'h03FF_FFFF, 1, 3'd0, 4'h0, 8'hE0, 32'h03FF_FFFF, "R4");
    drain();

    // R8 overlap, R10 disable
    wr(16'h1840, 32'h07FF_A021); wr(16'h1844, 32'h0400_0000); wr(16'h184C, 32'h3000_0000);
    lookup(32'h0412_3456, 1, 3'd1, 4'h1, 8'hD0, 32'h0812_3456, "R8");
    lookup(32'h0012_0000, 1, 3'd0, 4'h0, 8'hE0, 32'h0012_0000, "R8");
    wr(16'h1820, 32'h03FF_E000);
    lookup(32'h0012_0000, 1, 3'd2, 4'h2, 8'hA0, 32'h3012_0000, "R10");
    drain();

    // R7 range gating
    wr(16'h1850, 32'h0000_7731); wr(16'h1854, 32'h1000_0000); wr(16'h185C, 32'h4000_0000);
    miss(32'h1000_0010, "R7");
    wr(16'h0020, 32'h1000_0000); wr(16'h1808, 32'h0000_0001);
    lookup(32'h1000_0010, 1, 3'd3, 4'h3, 8'h77, 32'h4000_0010, "R7");
    wr(16'h1804, 32'h0FFF_0000);
    miss(32'h0412_3456, "R7");
    wr(16'h1804, 32'h0FFF_0001);
    miss(32'h9000_0000, "R9");
    drain();

    // R11 burst under stalls
    bp_mode = 1'b1;
    lookup(32'h0412_3456, 1, 3'd1, 4'h1, 8'hD0, 32'h0812_3456, "R11");
    lookup(32'h0800_1234, 1, 3'd5, 4'h5, 8'hBB, 32'h2222_1234, "R11");
    lookup(32'h1000_0010, 1, 3'd3, 4'h3, 8'h77, 32'h4000_0010, "R11");
    miss(32'h9000_0000, "R11");
    lookup(32'h0012_0000, 1, 3'd2, 4'h2, 8'hA0, 32'h3012_0000, "R11");
    drain();
    bp_mode = 1'b0;
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule